// File: doc/BRIEF.md
# PLL Control Register with Clock-Source Interlock

This block is the software-visible control word of a clock generator's PLL. It stores a PLL enable bit, a bit that selects the VCO clock as the base clock, a reference divider R, a feedback multiplier N and a range factor L. Software changes all of them with a single bus write. The block accepts only the combinations of enable and source select that keep the clock tree safe. If a write would break an interlock rule, the block holds the affected bit at its old value. The other fields of that same write still land.

Downstream logic receives cleaned-up values from this block. R and N come out with zero mapped to one. The PLL-enable and VCO-select outputs are both forced low whenever L is zero. A read returns the stored bits as they really are, so software can compare them with what it wrote and see whether a write was refused.

Top module: `pll_ctl_reg`

## Requirements
- R1: After reset the enable and select bits are 0, and R, N and L hold their reset parameters (defaults 1, 16 and 2).
- R2: `r_eff_o` and `n_eff_o` equal the stored R and N, except that a stored 0 gives 1.
- R3: While stored L is 0, `pll_on_o` and `vco_sel_o` are both 0, whatever the stored enable and select bits are.
- R4: A write that tries to set the select bit while the stored enable bit is 0 leaves the select bit at 0.
- R5: A write that tries to set the select bit with L = 0 in that same write leaves the select bit at 0.
- R6: A write that tries to clear the enable bit while the stored select bit is 1 leaves the enable bit at 1.
- R7: A write that would change both the enable bit and the select bit leaves both at their previous values.
- R8: The R, N and L fields of a write are stored even when its enable or select change is refused.
- R9: `rd_data` returns the stored word with this layout: enable at bit 0, select at bit 1, R at [RW+1:2], N at the next NW bits, and L at the top LW bits.
- R10: Legal sequences take effect on the clock edge where `wr_en` is high. These are: setting enable, then setting select, and clearing select, then clearing enable.
- R11: In a cycle where `wr_en` is low, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole control word |
| wr_data | input | 2+RW+NW+LW | Value to write |
| rd_data | output | 2+RW+NW+LW | Stored control word |
| pll_on_o | output | 1 | Effective PLL enable |
| vco_sel_o | output | 1 | Effective base-clock select (1 = VCO clock) |
| r_eff_o | output | RW | Effective reference divider |
| n_eff_o | output | NW | Effective feedback multiplier |
| l_o | output | LW | Stored range factor |

## Verification
The bench drives writes that try each enable/select transition from each stored state. It covers a select attempt with enable off, a select attempt paired with a zero L, an enable clear while the VCO clock is selected, and a write that flips both bits at once. Reading the word back after each of these shows which bit was refused and confirms that the divider fields of the same write still landed. Writes with zero and all-ones R, N and L show the zero-to-one mapping apart from plain pass-through. An idle cycle with garbage on the data lines shows that the word holds while the strobe is low.

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg #(
  parameter int RW = 4,
  parameter int NW = 8,
  parameter int LW = 4,
  parameter logic [RW-1:0] R_RST = 'd1,
  parameter logic [NW-1:0] N_RST = 'd16,
  parameter logic [LW-1:0] L_RST = 'd2,
  localparam int DW = 2 + RW + NW + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          pll_on_o,
  output logic          vco_sel_o,
  output logic [RW-1:0] r_eff_o,
  output logic [NW-1:0] n_eff_o,
  output logic [LW-1:0] l_o
);
  localparam int RLO = 2;
  localparam int NLO = RLO + RW;
  localparam int LLO = NLO + NW;

  logic          en_q, sel_q;
  logic [RW-1:0] r_q;
  logic [NW-1:0] n_q;
  logic [LW-1:0] l_q;

  wire          req_en  = wr_data[0];
  wire          req_sel = wr_data[1];
  wire [LW-1:0] req_l   = wr_data[LLO +: LW];

  wire dual   = (req_en != en_q) && (req_sel != sel_q);
  wire sel_ok = !dual && !(req_sel && !sel_q && (!en_q || req_l == '0));
  wire en_ok  = !dual && !(!req_en && en_q && sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      r_q   <= R_RST;
      n_q   <= N_RST;
      l_q   <= L_RST;
    end else if (wr_en) begin
      if (sel_ok) sel_q <= req_sel;
      if (en_ok)  en_q  <= req_en;
      r_q <= wr_data[RLO +: RW];
      n_q <= wr_data[NLO +: NW];
      l_q <= req_l;
    end
  end

  wire l_live = |l_q;

  assign rd_data   = {l_q, n_q, r_q, sel_q, en_q};
  assign pll_on_o  = en_q & l_live;
  assign vco_sel_o = sel_q & l_live;
  assign r_eff_o   = (r_q == '0) ? {{(RW-1){1'b0}}, 1'b1} : r_q;
  assign n_eff_o   = (n_q == '0) ? {{(NW-1){1'b0}}, 1'b1} : n_q;
  assign l_o       = l_q;
endmodule

// File: rtl/pll_ctl_reg_chk.sv
module pll_ctl_reg_chk #(
  parameter int RW = 4,
  parameter int NW = 8,
  parameter int LW = 4,
  localparam int DW = 2 + RW + NW + LW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] rd_data,
  input logic          pll_on_o,
  input logic          vco_sel_o,
  input logic [RW-1:0] r_eff_o,
  input logic [NW-1:0] n_eff_o
);
  localparam int LLO = 2 + RW + NW;
  wire [LW-1:0] l_f = rd_data[LLO +: LW];

  AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) rd_data[1] |-> rd_data[0]); // R4
  AST_EN_HELD_BY_SEL: assert property (@(posedge clk) disable iff (!rst_n) $past(rd_data[1]) && $fell(rd_data[0]) |-> 1'b0); // R6
  AST_NO_DUAL_FLIP: assert property (@(posedge clk) disable iff (!rst_n) !((rd_data[0] != $past(rd_data[0])) && (rd_data[1] != $past(rd_data[1])))); // R7
  AST_LZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n) (l_f == '0) |-> (!pll_on_o && !vco_sel_o)); // R3
  AST_EFF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (r_eff_o != '0) && (n_eff_o != '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(rd_data)); // R11
endmodule

bind pll_ctl_reg pll_ctl_reg_chk #(.RW(RW), .NW(NW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .pll_on_o(pll_on_o), .vco_sel_o(vco_sel_o), .r_eff_o(r_eff_o), .n_eff_o(n_eff_o)
);

// File: tb/pll_ctl_reg_bench.sv
`timescale 1ns/1ps
module pll_ctl_reg_bench;
  localparam int RW = 4, NW = 8, LW = 4;
  localparam int DW = 2 + RW + NW + LW;
  localparam int EW = DW + 2 + RW + NW + LW;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic pll_on_o, vco_sel_o;
  logic [RW-1:0] r_eff_o;
  logic [NW-1:0] n_eff_o;
  logic [LW-1:0] l_o;

  always #4 clk = ~clk;

  pll_ctl_reg #(.RW(RW), .NW(NW), .LW(LW)) u_pll_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pll_on_o(pll_on_o), .vco_sel_o(vco_sel_o), .r_eff_o(r_eff_o), .n_eff_o(n_eff_o), .l_o(l_o)
  );

  logic [EW-1:0] exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic m_en, m_sel;
  logic [RW-1:0] m_r;
  logic [NW-1:0] m_n;
  logic [LW-1:0] m_l;

  function automatic logic [DW-1:0] word(logic e, logic s, logic [RW-1:0] r, logic [NW-1:0] n, logic [LW-1:0] l);
    return {l, n, r, s, e};
  endfunction

  task automatic push(string tag);
    logic [RW-1:0] re = (m_r == 0) ? RW'(1) : m_r;
    logic [NW-1:0] ne = (m_n == 0) ? NW'(1) : m_n;
    exp_q.push_back({word(m_en, m_sel, m_r, m_n, m_l), m_en && m_l != 0, m_sel && m_l != 0, re, ne, m_l});
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic e, logic s, logic [RW-1:0] r, logic [NW-1:0] n, logic [LW-1:0] l, string tag);
    logic both;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = word(e, s, r, n, l);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    both = (e != m_en) && (s != m_sel);
    if (!both) begin
      if (!(s && !m_sel && (!m_en || l == 0))) m_sel = s;
      if (!(!e && m_en && m_sel)) m_en = e;
    end
    m_r = r; m_n = n; m_l = l;
    push(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '1;
    @(posedge clk);
    #1;
    push(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [EW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({rd_data, pll_on_o, vco_sel_o, r_eff_o, n_eff_o, l_o} !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t,
                 {rd_data, pll_on_o, vco_sel_o, r_eff_o, n_eff_o, l_o}, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_sel = 0; m_r = 4'd1; m_n = 8'd16; m_l = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    push("R1 reset state");
    wr(1'b0, 1'b1, 4'd1, 8'd16, 4'd2, "R4 select with enable off");
    wr(1'b1, 1'b0, 4'd1, 8'd16, 4'd2, "R10 set enable");
    wr(1'b1, 1'b1, 4'd3, 8'd20, 4'd0, "R5 select with L zero, R8 fields land");
    wr(1'b1, 1'b1, 4'd3, 8'd20, 4'd5, "R10 set select");
    wr(1'b0, 1'b1, 4'd6, 8'd0, 4'd5, "R6 clear enable while selected, R2 N zero");
    wr(1'b0, 1'b0, 4'd6, 8'd9, 4'd5, "R7 dual flip refused, R8");
    idle("R11 strobe low holds word");
    wr(1'b1, 1'b1, 4'd6, 8'd9, 4'd0, "R3 L zero forces outputs off");
    wr(1'b1, 1'b0, 4'd0, 8'd9, 4'd0, "R10 clear select, R2 R zero");
    wr(1'b0, 1'b0, 4'd0, 8'd0, 4'd7, "R10 clear enable, R2 both zero");
    wr(1'b1, 1'b0, 4'd15, 8'd255, 4'd15, "R9 R2 all-ones pass through");
    wr(1'b0, 1'b1, 4'd15, 8'd255, 4'd15, "R7 dual flip from enabled idle");
    wr(1'b1, 1'b1, 4'd8, 8'd128, 4'd1, "R10 select with L one");
    idle("R11 hold with select on");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule